// File: doc/BRIEF.md
# I2C Short Transaction Sequencer

This block runs a whole small I2C master transaction by itself, so software does no work per byte. Software first fills a transmit window of two 32-bit words, then writes one control word. The control word gives the target address, the address width, which phases run, the transmit and receive byte counts and the turnaround style. The sequencer then sends a stream of byte-level commands (START, STOP, write a byte, read a byte) to an attached byte-level bus master. It waits for each command to complete before it sends the next one.

Three shapes of transaction are supported: write only, read only, and a write followed by a read. The read phase of the last shape is opened either by a repeated START or by STOP followed by a new START. Received bytes fill a receive window of two 32-bit words. When the closing STOP completes, a completion cause flag is raised, and an error flag records whether the target refused any address or data byte. Both windows hold bytes little-endian: byte k of the transaction sits in bits [8k+7:8k] of the flat window, so byte 0 is the low byte of the low word.

Top module: `i2c_seq_top`

## Requirements
- R1: After reset, `busy`, `cause`, `err` and `bm_req` are 0 and `rx_data` is all zeros.
- R2: `reg_sel` codes are 0 = control word, 1 = cause register, 2 = transmit low word, 3 = transmit high word. The control word fields are: bit0 write phase, bit1 read phase, bits[11:2] target address, bit12 10-bit address mode, bits[15:13] transmit count minus one, bits[18:16] receive count minus one, bit19 enable, bit20 repeated START. A transaction starts only when this word is written while idle with bit19 set and at least one of bit0/bit1 set. `bm_op` codes are 0 START, 1 STOP, 2 write byte, 3 read byte.
- R3: A 7-bit write issues START, then the byte {addr[6:0],0}, then 1 to 8 transmit bytes starting at byte 0 of the low word, then STOP.
- R4: A 7-bit read issues START, then {addr[6:0],1}, then the read commands, then STOP. `bm_nack` is 1 only on the last read. Received byte j is stored at `rx_data[8j+7:8j]`, and bytes that were not received read as 0.
- R5: In a write followed by a read, the read phase follows the last transmit byte. With bit20 set it starts with START and no STOP before it. With bit20 clear a STOP and then a START come before it.
- R6: In 10-bit mode an address is the header {5'b11110,addr[9:8],dir} followed by addr[7:0]. A read that is not continuing a write sends header(W), low byte, START, header(R). After a write with repeated START, the read address is header(R) alone.
- R7: If the target does not acknowledge an address or data write (`bm_ack`=0 at `bm_done`), the next and only further command is STOP, and `err` is set.
- R8: `cause` rises and `busy` falls in the cycle after the final STOP completes. Writing the cause register with bit0 = 0 clears `cause`. `err` clears when the next transaction starts.
- R9: Writing the control word with bit19 clear while busy returns the block to idle on the next cycle, drops `bm_req` and leaves `cause` unchanged.
- R10: While busy, writes to the transmit words and control writes with bit19 set have no effect.
- R11: `bm_req` is low for at least one cycle after each `bm_done`, and the command fields stay stable while `bm_req` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select code |
| reg_wdata | input | 32 | Register write data |
| rx_data | output | 64 | Receive window, byte 0 lowest |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | Last transaction saw a refused byte |
| cause | output | 1 | Completion cause flag |
| bm_req | output | 1 | Command request to byte master |
| bm_op | output | 2 | Command code |
| bm_wbyte | output | 8 | Byte to send for write commands |
| bm_nack | output | 1 | Answer NACK on this read |
| bm_done | input | 1 | Byte master completed the command (one-cycle pulse) |
| bm_ack | input | 1 | Target acknowledged the written byte |
| bm_rbyte | input | 8 | Byte received by a read command |

## Verification
The bench builds the block with its default parameters: 32-bit words and a two-word window. This makes eight-byte transfers and three-bit count fields possible, so the full length range from 1 to 8 bytes at both ends can be driven directly. A behavioural model of the byte master answers each command with a latency that varies. It checks every command against a queue predicted from the control word, and every cycle it compares the busy, cause and error flags. This covers both address widths, both turnaround styles, refused bytes, aborts, and writes made while busy.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } bm_op_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_ISSUE,
      PH_WAIT
   } phase_e;

   typedef enum logic [2:0] {
      STP_START,
      STP_ADDR1,
      STP_ADDR2,
      STP_TX,
      STP_RX,
      STP_MIDSTOP,
      STP_STOP
   } step_e;
endpackage

// File: rtl/i2c_seq_txwin.sv
module i2c_seq_txwin #(
   parameter int WORD_W    = 32,
   parameter int WIN_WORDS = 2,
   parameter int SEL_W     = 2,
   parameter int LEN_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [SEL_W-1:0]  sel,
   input  logic [WORD_W-1:0] wdata,
   input  logic              busy,
   input  logic [LEN_W-1:0]  rd_idx,
   output logic [7:0]        tx_byte
);
   localparam int WIN_W = WORD_W * WIN_WORDS;

   logic [WIN_W-1:0] win;

   for (genvar k = 0; k < WIN_WORDS; k++) begin : g_word
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr && !busy && sel == SEL_W'(k + 2))
            q <= wdata;
      end
      assign win[k*WORD_W +: WORD_W] = q;
   end

   assign tx_byte = win[{rd_idx, 3'b000} +: 8];

   // R10: window frozen while a transaction runs
   a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(win));
endmodule

// File: rtl/i2c_seq_rxwin.sv
module i2c_seq_rxwin #(
   parameter int NBYTES = 8,
   parameter int LEN_W  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                we,
   input  logic [LEN_W-1:0]    idx,
   input  logic [7:0]          byte_in,
   output logic [NBYTES*8-1:0] data
);
   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (clr)
            q <= '0;
         else if (we && idx == LEN_W'(i))
            q <= byte_in;
      end
      assign data[i*8 +: 8] = q;
   end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
   import i2c_seq_pkg::*;
#(
   parameter int LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             abort,
   input  logic             cause_clr,
   input  logic             cfg_wr,
   input  logic             cfg_rd,
   input  logic             cfg_ten,
   input  logic             cfg_rs,
   input  logic [9:0]       cfg_addr,
   input  logic [LEN_W-1:0] cfg_txl,
   input  logic [LEN_W-1:0] cfg_rxl,
   input  logic [7:0]       tx_byte,
   input  logic             bm_done,
   input  logic             bm_ack,
   output logic             busy,
   output logic             err,
   output logic             cause,
   output logic             bm_req,
   output logic [1:0]       bm_op,
   output logic [7:0]       bm_wbyte,
   output logic             bm_nack,
   output logic [LEN_W-1:0] tx_idx,
   output logic [LEN_W-1:0] rx_idx,
   output logic             rx_we
);
   phase_e           ph;
   step_e            step;
   logic             c_rd, c_ten, c_rs, in_rd, adr_r;
   logic [9:0]       c_addr;
   logic [LEN_W-1:0] c_txl, c_rxl;
   bm_op_e           is_op;
   logic [7:0]       is_b;
   logic             is_nk, fin;

   assign busy  = (ph != PH_IDLE);
   assign fin   = (ph == PH_WAIT) && bm_done && !abort;
   assign rx_we = fin && (step == STP_RX);

   always_comb begin
      is_op = OP_WRITE;
      is_b  = 8'h00;
      is_nk = 1'b0;
      case (step)
         STP_START:            is_op = OP_START;
         STP_STOP,
         STP_MIDSTOP:          is_op = OP_STOP;
         STP_ADDR1:            is_b  = c_ten ? {5'b11110, c_addr[9:8], adr_r}
                                             : {c_addr[6:0], adr_r};
         STP_ADDR2:            is_b  = c_addr[7:0];
         STP_TX:               is_b  = tx_byte;
         STP_RX: begin
            is_op = OP_READ;
            is_nk = (rx_idx == c_rxl);
         end
         default:              is_op = OP_STOP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cause <= 1'b0;
      else if (fin && step == STP_STOP)
         cause <= 1'b1;
      else if (cause_clr)
         cause <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         step     <= STP_START;
         {c_rd, c_ten, c_rs, in_rd, adr_r} <= '0;
         c_addr   <= '0;
         c_txl    <= '0;
         c_rxl    <= '0;
         tx_idx   <= '0;
         rx_idx   <= '0;
         err      <= 1'b0;
         bm_req   <= 1'b0;
         bm_op    <= OP_START;
         bm_wbyte <= '0;
         bm_nack  <= 1'b0;
      end else if (abort) begin
         ph     <= PH_IDLE;
         bm_req <= 1'b0;
      end else begin
         case (ph)
            PH_IDLE: if (go) begin
               c_rd   <= cfg_rd;
               c_ten  <= cfg_ten;
               c_rs   <= cfg_rs;
               c_addr <= cfg_addr;
               c_txl  <= cfg_txl;
               c_rxl  <= cfg_rxl;
               in_rd  <= !cfg_wr;
               adr_r  <= !cfg_wr && !cfg_ten;
               tx_idx <= '0;
               rx_idx <= '0;
               err    <= 1'b0;
               step   <= STP_START;
               ph     <= PH_ISSUE;
            end
            PH_ISSUE: begin
               bm_req   <= 1'b1;
               bm_op    <= is_op;
               bm_wbyte <= is_b;
               bm_nack  <= is_nk;
               ph       <= PH_WAIT;
            end
            PH_WAIT: if (bm_done) begin
               bm_req <= 1'b0;
               ph     <= PH_ISSUE;
               case (step)
                  STP_START: step <= STP_ADDR1;
                  STP_ADDR1:
                     if (!bm_ack) begin err <= 1'b1; step <= STP_STOP; end
                     else if (adr_r) step <= STP_RX;
                     else if (c_ten) step <= STP_ADDR2;
                     else            step <= STP_TX;
                  STP_ADDR2:
                     if (!bm_ack) begin err <= 1'b1; step <= STP_STOP; end
                     else if (in_rd) begin adr_r <= 1'b1; step <= STP_START; end
                     else step <= STP_TX;
                  STP_TX:
                     if (!bm_ack) begin err <= 1'b1; step <= STP_STOP; end
                     else if (tx_idx == c_txl) begin
                        if (!c_rd) step <= STP_STOP;
                        else if (c_rs) begin
                           in_rd <= 1'b1;
                           adr_r <= 1'b1;
                           step  <= STP_START;
                        end else step <= STP_MIDSTOP;
                     end else tx_idx <= tx_idx + 1'b1;
                  STP_MIDSTOP: begin
                     in_rd <= 1'b1;
                     adr_r <= !c_ten;
                     step  <= STP_START;
                  end
                  STP_RX:
                     if (rx_idx == c_rxl) step <= STP_STOP;
                     else rx_idx <= rx_idx + 1'b1;
                  default: ph <= PH_IDLE;
               endcase
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   // R11: a gap follows every completion
   a_r11_gap: assert property (@(posedge clk) disable iff (!rst_n)
      bm_done |=> !bm_req);
   // R11: command fields held while requested
   a_r11_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (bm_req && $past(bm_req)) |-> ($stable(bm_op) && $stable(bm_wbyte) && $stable(bm_nack)));
   // R7: after a refused byte only STOP may be requested
   a_r7_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (err && bm_req) |-> (bm_op == OP_STOP));
   // R8: cause rises only as the block goes idle
   a_r8_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause) |-> !busy);
   // R2: no bus traffic while idle
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bm_req);
endmodule

// File: rtl/i2c_seq_top.sv
module i2c_seq_top #(
   parameter int WORD_W    = 32,
   parameter int WIN_WORDS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic [$clog2(WIN_WORDS+2)-1:0] reg_sel,
   input  logic [WORD_W-1:0]             reg_wdata,
   output logic [WORD_W*WIN_WORDS-1:0]   rx_data,
   output logic                          busy,
   output logic                          err,
   output logic                          cause,
   output logic                          bm_req,
   output logic [1:0]                    bm_op,
   output logic [7:0]                    bm_wbyte,
   output logic                          bm_nack,
   input  logic                          bm_done,
   input  logic                          bm_ack,
   input  logic [7:0]                    bm_rbyte
);
   localparam int NBYTES  = WORD_W * WIN_WORDS / 8;
   localparam int LEN_W   = $clog2(NBYTES);
   localparam int SEL_W   = $clog2(WIN_WORDS + 2);
   localparam int ADR_LSB = 2;
   localparam int TEN_BIT = 12;
   localparam int TXL_LSB = 13;
   localparam int RXL_LSB = TXL_LSB + LEN_W;
   localparam int EN_BIT  = RXL_LSB + LEN_W;
   localparam int RS_BIT  = EN_BIT + 1;

   if (WORD_W % 8 != 0) begin : g_chk_word
      $error("word width must be a whole number of bytes");
   end
   if ((1 << LEN_W) != NBYTES) begin : g_chk_pow
      $error("window byte count must be a power of two");
   end
   if (RS_BIT >= WORD_W) begin : g_chk_fit
      $error("control fields do not fit in one word");
   end

   logic             ctrl_wr, go, abort, cause_clr, rx_we;
   logic [LEN_W-1:0] tx_idx, rx_idx;
   logic [7:0]       tx_byte;

   assign ctrl_wr   = reg_wr && (reg_sel == SEL_W'(0));
   assign go        = ctrl_wr && reg_wdata[EN_BIT] && (reg_wdata[0] || reg_wdata[1]) && !busy;
   assign abort     = ctrl_wr && !reg_wdata[EN_BIT] && busy;
   assign cause_clr = reg_wr && (reg_sel == SEL_W'(1)) && !reg_wdata[0];

   i2c_seq_txwin #(.WORD_W(WORD_W), .WIN_WORDS(WIN_WORDS), .SEL_W(SEL_W), .LEN_W(LEN_W)) u_txwin (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .busy(busy), .rd_idx(tx_idx), .tx_byte(tx_byte));

   i2c_seq_rxwin #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_rxwin (
      .clk(clk), .rst_n(rst_n), .clr(go), .we(rx_we), .idx(rx_idx),
      .byte_in(bm_rbyte), .data(rx_data));

   i2c_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .cause_clr(cause_clr),
      .cfg_wr(reg_wdata[0]), .cfg_rd(reg_wdata[1]), .cfg_ten(reg_wdata[TEN_BIT]),
      .cfg_rs(reg_wdata[RS_BIT]), .cfg_addr(reg_wdata[ADR_LSB +: 10]),
      .cfg_txl(reg_wdata[TXL_LSB +: LEN_W]), .cfg_rxl(reg_wdata[RXL_LSB +: LEN_W]),
      .tx_byte(tx_byte), .bm_done(bm_done), .bm_ack(bm_ack),
      .busy(busy), .err(err), .cause(cause), .bm_req(bm_req), .bm_op(bm_op),
      .bm_wbyte(bm_wbyte), .bm_nack(bm_nack), .tx_idx(tx_idx), .rx_idx(rx_idx),
      .rx_we(rx_we));

   // R9: disabling while busy goes straight to idle
   a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !reg_wdata[EN_BIT] && busy) |=> (!busy && !bm_req && $stable(cause)));
endmodule

// File: tb/i2c_seq_bench.sv
module i2c_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [63:0] rx_data;
   logic        busy, err, cause, bm_req, bm_nack;
   logic [1:0]  bm_op;
   logic [7:0]  bm_wbyte;
   logic        bm_done = 1'b0;
   logic        bm_ack = 1'b1;
   logic [7:0]  bm_rbyte = '0;

   always #10 clk = ~clk;

   i2c_seq_top u_i2c_seq_top (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .rx_data(rx_data), .busy(busy), .err(err), .cause(cause), .bm_req(bm_req),
      .bm_op(bm_op), .bm_wbyte(bm_wbyte), .bm_nack(bm_nack), .bm_done(bm_done),
      .bm_ack(bm_ack), .bm_rbyte(bm_rbyte));

   typedef struct { logic [1:0] op; logic [7:0] b; logic nk; } ecmd_t;
   ecmd_t expq[$];

   int    n_chk = 0, n_fail = 0;
   string cur_rq = "R1";
   int    nack_pos = -1, pop_cnt = 0, rcount = 0, lat = 0;
   bit    cut = 0, seen = 0, flush = 0, mon_on = 0, last_fin = 0, last_nk = 0;
   bit    exp_busy = 0, exp_cause = 0, exp_err = 0;
   logic [7:0] txb [8];

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [7:0] rxval(input int j);
      return 8'(60 + j * 37);
   endfunction

   function automatic logic [31:0] mk_ctrl(input bit wr, input bit rd, input bit ten,
                                           input bit rs, input logic [9:0] a,
                                           input int n, input int m);
      logic [31:0] w = '0;
      w[0] = wr; w[1] = rd; w[11:2] = a; w[12] = ten;
      w[15:13] = (n > 0) ? 3'(n - 1) : 3'd0;
      w[18:16] = (m > 0) ? 3'(m - 1) : 3'd0;
      w[19] = 1'b1; w[20] = rs;
      return w;
   endfunction

   task automatic pushc(input logic [1:0] op, input logic [7:0] b, input logic nk);
      ecmd_t e;
      if (!cut) begin
         e.op = op; e.b = b; e.nk = nk;
         expq.push_back(e);
         if (op == 2'd2 && expq.size() - 1 == nack_pos) begin
            cut = 1;
            e.op = 2'd1; e.b = 8'h00; e.nk = 1'b0;
            expq.push_back(e);
         end
      end
   endtask

   task automatic push_rd_addr(input bit ten, input logic [9:0] a);
      if (ten) begin
         pushc(2'd2, {5'b11110, a[9:8], 1'b0}, 0);
         pushc(2'd2, a[7:0], 0);
         pushc(2'd0, 8'h00, 0);
         pushc(2'd2, {5'b11110, a[9:8], 1'b1}, 0);
      end else pushc(2'd2, {a[6:0], 1'b1}, 0);
   endtask

   task automatic build(input bit wr, input bit rd, input bit ten, input bit rs,
                        input logic [9:0] a, input int n, input int m);
      expq.delete();
      cut = 0;
      pushc(2'd0, 8'h00, 0);
      if (wr) begin
         pushc(2'd2, ten ? {5'b11110, a[9:8], 1'b0} : {a[6:0], 1'b0}, 0);
         if (ten) pushc(2'd2, a[7:0], 0);
         for (int i = 0; i < n; i++) pushc(2'd2, txb[i], 0);
         if (rd) begin
            if (rs) begin
               pushc(2'd0, 8'h00, 0);
               pushc(2'd2, ten ? {5'b11110, a[9:8], 1'b1} : {a[6:0], 1'b1}, 0);
            end else begin
               pushc(2'd1, 8'h00, 0);
               pushc(2'd0, 8'h00, 0);
               push_rd_addr(ten, a);
            end
         end
      end else push_rd_addr(ten, a);
      if (rd) for (int j = 0; j < m; j++) pushc(2'd3, 8'h00, (j == m - 1));
      pushc(2'd1, 8'h00, 0);
   endtask

   // kind: 0 plain, 1 starts a transaction, 2 abort, 3 cause clear
   task automatic wreg(input logic [1:0] sel, input logic [31:0] d, input int kind);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      case (kind)
         1: begin exp_busy = 1; exp_err = 0; end
         2: begin exp_busy = 0; flush = 1; expq.delete(); end
         3: exp_cause = 0;
         default: ;
      endcase
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic load_tx(input logic [31:0] lo, input logic [31:0] hi);
      for (int i = 0; i < 4; i++) begin
         txb[i] = lo[8*i +: 8];
         txb[i+4] = hi[8*i +: 8];
      end
      wreg(2'd2, lo, 0);
      wreg(2'd3, hi, 0);
   endtask

   int cur_m = 0;
   bit cur_rd = 0;

   task automatic start_txn(input string rq, input bit wr, input bit rd, input bit ten,
                            input bit rs, input logic [9:0] a, input int n, input int m,
                            input int nkpos);
      cur_rq = rq; nack_pos = nkpos; pop_cnt = 0; rcount = 0;
      cur_m = m; cur_rd = rd;
      build(wr, rd, ten, rs, a, n, m);
      wreg(2'd0, mk_ctrl(wr, rd, ten, rs, a, n, m), 1);
   endtask

   task automatic finish_txn();
      int w = 0;
      logic [63:0] erx = '0;
      while (exp_busy && w < 5000) begin
         @(negedge clk);
         w++;
      end
      chk(w < 5000, cur_rq, "transaction completes", 64'(w), 64'd0);
      @(negedge clk);
      chk(expq.size() == 0, cur_rq, "all commands issued", 64'(expq.size()), 64'd0);
      chk(cause == 1'b1 && !busy, "R8", "cause raised at end", {cause, busy}, 2'b10);
      chk(err == (nack_pos >= 0), "R7", "err after transaction", err, (nack_pos >= 0));
      if (cur_rd && nack_pos < 0) begin
         for (int j = 0; j < cur_m; j++) erx[8*j +: 8] = rxval(j);
         chk(rx_data == erx, "R4", "receive window", rx_data, erx);
      end
      wreg(2'd1, 32'h0, 3);
      @(negedge clk);
      chk(cause == 1'b0, "R8", "cause cleared by zero write", cause, 0);
   endtask

   task automatic run_txn(input string rq, input bit wr, input bit rd, input bit ten,
                          input bit rs, input logic [9:0] a, input int n, input int m,
                          input int nkpos);
      start_txn(rq, wr, rd, ten, rs, a, n, m, nkpos);
      finish_txn();
   endtask

   // Byte master model and per-cycle comparison
   always @(posedge clk) begin
      ecmd_t e;
      #2;
      if (mon_on) begin
         if (flush) begin
            bm_done = 0; seen = 0; flush = 0;
         end else if (bm_done) begin
            bm_done = 0;
            chk(!bm_req, "R11", "request gap after done", bm_req, 0);
            if (last_nk) exp_err = 1;
            if (last_fin) begin exp_busy = 0; exp_cause = 1; end
         end else if (bm_req) begin
            if (!seen) begin
               if (expq.size() == 0) begin
                  chk(0, cur_rq, "unexpected command", {bm_op, bm_wbyte}, 0);
                  last_fin = 0; last_nk = 0;
               end else begin
                  e = expq.pop_front();
                  chk(bm_op == e.op && bm_wbyte == e.b && bm_nack == e.nk, cur_rq,
                      "command op/byte/nack", {bm_op, bm_wbyte, bm_nack}, {e.op, e.b, e.nk});
                  last_fin = (e.op == 2'd1) && (expq.size() == 0);
                  last_nk  = (e.op == 2'd2) && (pop_cnt == nack_pos);
                  bm_ack   = !last_nk;
                  if (e.op == 2'd3) begin
                     bm_rbyte = rxval(rcount);
                     rcount++;
                  end
                  pop_cnt++;
               end
               seen = 1;
               lat = pop_cnt % 3;
            end else if (lat > 0) lat--;
            else begin
               bm_done = 1;
               seen = 0;
            end
         end
         chk(busy == exp_busy && cause == exp_cause && err == exp_err, "R8",
             "busy/cause/err per cycle", {busy, cause, err}, {exp_busy, exp_cause, exp_err});
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !cause && !err && !bm_req, "R1", "reset flags", {busy, cause, err, bm_req}, 0);
      chk(rx_data == 64'h0, "R1", "reset receive window", rx_data, 0);
      mon_on = 1;

      load_tx(32'h44332211, 32'h88776655);
      run_txn("R3", 1, 0, 0, 0, 10'h050, 3, 0, -1);
      run_txn("R3", 1, 0, 0, 0, 10'h07F, 8, 0, -1);
      run_txn("R3", 1, 0, 0, 0, 10'h001, 1, 0, -1);
      run_txn("R4", 0, 1, 0, 0, 10'h048, 4, 4, -1);
      run_txn("R4", 0, 1, 0, 0, 10'h023, 1, 8, -1);
      run_txn("R4", 0, 1, 0, 0, 10'h023, 1, 1, -1);
      run_txn("R5", 1, 1, 0, 1, 10'h050, 2, 3, -1);
      run_txn("R5", 1, 1, 0, 0, 10'h051, 1, 2, -1);
      run_txn("R6", 1, 0, 1, 0, 10'h2A5, 2, 0, -1);
      run_txn("R6", 0, 1, 1, 0, 10'h3C3, 1, 2, -1);
      run_txn("R6", 1, 1, 1, 1, 10'h1F0, 3, 2, -1);
      run_txn("R6", 1, 1, 1, 0, 10'h105, 1, 1, -1);
      run_txn("R7", 0, 1, 0, 0, 10'h033, 1, 4, 1);
      run_txn("R7", 1, 0, 0, 0, 10'h033, 4, 0, 3);
      run_txn("R7", 1, 1, 1, 1, 10'h2EE, 2, 2, 2);

      // R10: window and control writes while busy are ignored
      start_txn("R10", 1, 0, 0, 0, 10'h05A, 8, 0, -1);
      repeat (3) @(negedge clk);
      wreg(2'd2, 32'hDEADBEEF, 0);
      wreg(2'd3, 32'hCAFEF00D, 0);
      wreg(2'd0, mk_ctrl(0, 1, 0, 0, 10'h011, 1, 2), 0);
      finish_txn();
      run_txn("R10", 1, 0, 0, 0, 10'h05A, 8, 0, -1);

      // R2: enable with neither phase selected starts nothing
      wreg(2'd0, 32'h0008_0000 | (32'h50 << 2), 0);
      repeat (4) @(negedge clk);
      chk(!busy && !bm_req, "R2", "no phase selected stays idle", {busy, bm_req}, 0);

      // R9: abort mid-transaction
      start_txn("R9", 0, 1, 0, 0, 10'h066, 1, 8, -1);
      repeat (15) @(negedge clk);
      wreg(2'd0, 32'h0, 2);
      repeat (2) @(negedge clk);
      chk(!busy && !bm_req && !cause, "R9", "abort returns idle", {busy, bm_req, cause}, 0);
      run_txn("R9", 1, 1, 0, 1, 10'h066, 2, 2, -1);

      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule